// File: doc/BRIEF.md
# Transmit Byte Queue with Downward Empty Thresholds

This block holds up to sixteen outgoing bytes between the writers that fill it and the serializer that drains it. A processor or a DMA engine pushes bytes with a single write strobe and a source indicator. A frame tick marks the moment at which the serializer can accept one whole byte. On such a tick, while transmit enable is high and the queue holds data, the oldest byte is handed out with a one-cycle valid pulse.

Two status flags summarize the queue. The data-empty flag says the fill level has fallen to or below a selectable low-water mark. The transmission-end flag says the last byte has left. The flags drive a level interrupt and a one-cycle DMA request, so a DMA engine can refill the queue without software. Clearing the flags depends on the writer. DMA writes clear them automatically, while processor writes leave them alone and software clears them with a status write. That status write only succeeds while the condition behind the flag is no longer true.

Top module: `tx_byte_queue`

## Requirements
- R1: After reset, level is 0, flag_empty and flag_end are 1, and irq, dma_req and tx_valid are 0.
- R2: A byte leaves only on a cycle with frame_tick=1, tx_en=1 and level non-zero. It appears on tx_data with tx_valid high for exactly the cycle after that edge, in first-in first-out order, and level drops by one.
- R3: A write while level is 16 is dropped: level stays 16 and the byte is never sent.
- R4: thr_sel chooses the low-water mark: 0 gives 8, 1 gives 4, 2 gives 2, 3 gives 1. After a send that leaves level at or below the mark, flag_empty is set, dma_req pulses for one cycle, and irq is set if irq_en is 1. A send that leaves level above the mark changes none of these.
- R5: A send that leaves level at 0 sets flag_end.
- R6: A write with wr_from_dma=1 clears flag_end. If level after that write is above the mark, it also clears flag_empty and irq.
- R7: A write with wr_from_dma=0 leaves flag_empty, flag_end and irq unchanged.
- R8: fifo_clr empties the queue and sets both flags. irq is set and dma_req pulses only when irq_en is 1. fifo_clr overrides a write or a send in the same cycle.
- R9: A status write (sts_wr=1) with sts_end_val=0 clears flag_end only if level is non-zero. With sts_empty_val=0 it clears flag_empty, and irq with it, only if level is above the mark. A value of 1 leaves the flag as it is.
- R10: irq is low in the same cycle that irq_en is low. An interrupt pending when irq_en fell does not come back when irq_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_from_dma | input | 1 | 1 = write comes from DMA, 0 = from the processor |
| wr_data | input | 8 | Byte to queue |
| frame_tick | input | 1 | One-cycle strobe: serializer can take a byte |
| tx_en | input | 1 | Transmit enable |
| thr_sel | input | 2 | Low-water mark select |
| fifo_clr | input | 1 | Queue reset strobe |
| irq_en | input | 1 | Transmit interrupt enable |
| sts_wr | input | 1 | Status write strobe |
| sts_end_val | input | 1 | Value written to the transmission-end flag |
| sts_empty_val | input | 1 | Value written to the data-empty flag |
| tx_data | output | 8 | Byte handed to the serializer |
| tx_valid | output | 1 | tx_data is valid (one-cycle pulse) |
| level | output | 5 | Number of queued bytes |
| flag_empty | output | 1 | Level at or below the low-water mark |
| flag_end | output | 1 | Transmission ended, queue drained |
| irq | output | 1 | Transmit interrupt |
| dma_req | output | 1 | One-cycle DMA refill request |

## Verification
The bench targets the boundary where level equals the mark for each select value. A design that compared with the wrong inequality would fire dma_req one byte early or late. It targets the asymmetry between writers: a design that let processor writes clear flags would drop irq with data still owed to software, and one that ignored DMA writes would leave irq asserted after a refill. It also fills the queue to 16 and writes once more, which exposes a design that wraps its pointer and overwrites or emits the extra byte. Finally, it applies status writes while the condition still holds and a queue reset together with a write and a tick. These show whether the conditional clears and the priority of the reset are honoured.

// File: rtl/txq_pkg.sv
package txq_pkg;

    // Registered flag state of the queue
    typedef struct packed {
        logic empty;   // level at or below low-water mark
        logic fin;     // queue drained after a send
        logic irq;     // pending transmit interrupt
        logic dma;     // one-cycle refill request
    } txq_flag_t;

    // Low-water mark for a select value: base halved per step
    function automatic int unsigned txq_mark(input int unsigned base, input int unsigned sel);
        return base >> sel;
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic [CW-1:0] level,
    output logic [CW-1:0] level_nx
);

    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dq;
        logic          vld;
    } st_t;

    st_t st_q, st_d;
    logic [DW-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d.head = '0;
            st_d.tail = '0;
            st_d.cnt  = '0;
        end else begin
            if (pop) begin
                st_d.dq   = mem[st_q.head];
                st_d.vld  = 1'b1;
                st_d.head = bump(st_q.head);
            end
            if (push) begin
                st_d.tail = bump(st_q.tail);
            end
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[st_q.tail] <= din;
        end
    end

    assign dout     = st_q.dq;
    assign dout_vld = st_q.vld;
    assign level    = st_q.cnt;
    assign level_nx = st_d.cnt;

    // R2: a pop never happens on an empty queue
    assert_pop_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> (st_q.cnt != '0));

endmodule

// File: rtl/txq_limit.sv
module txq_limit #(
    parameter int DEPTH    = 16,
    parameter int SW       = 2,
    parameter int THR_BASE = 8,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int NSEL    = 1 << SW
) (
    input  logic [SW-1:0] sel,
    input  logic [CW-1:0] level_now,
    input  logic [CW-1:0] level_nx,
    output logic          above_now,
    output logic          above_nx,
    output logic          zero_now,
    output logic          zero_nx
);

    logic [CW-1:0] mark_tab [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_mark
        assign mark_tab[g] = CW'(txq_pkg::txq_mark(THR_BASE, g));
    end

    logic [CW-1:0] mark;
    assign mark      = mark_tab[sel];
    assign above_now = level_now > mark;
    assign above_nx  = level_nx > mark;
    assign zero_now  = level_now == '0;
    assign zero_nx   = level_nx == '0;

endmodule

// File: rtl/txq_flags.sv
module txq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pop,
    input  logic push_dma,
    input  logic irq_en,
    input  logic sts_wr,
    input  logic sts_end_val,
    input  logic sts_empty_val,
    input  logic above_now,
    input  logic above_nx,
    input  logic zero_now,
    input  logic zero_nx,
    output logic flag_empty,
    output logic flag_end,
    output logic irq,
    output logic dma_req
);

    import txq_pkg::*;

    txq_flag_t f_q, f_d;

    always_comb begin
        f_d     = f_q;
        f_d.dma = 1'b0;
        // software clears, honoured only once the condition is gone
        if (sts_wr) begin
            if (!sts_end_val && !zero_now) begin
                f_d.fin = 1'b0;
            end
            if (!sts_empty_val && above_now) begin
                f_d.empty = 1'b0;
                f_d.irq   = 1'b0;
            end
        end
        // a send that reaches the low-water mark
        if (pop && !above_nx) begin
            f_d.empty = 1'b1;
            f_d.dma   = 1'b1;
            if (irq_en) begin
                f_d.irq = 1'b1;
            end
        end
        if (pop && zero_nx) begin
            f_d.fin = 1'b1;
        end
        // DMA refill clears automatically
        if (push_dma) begin
            f_d.fin = 1'b0;
            if (above_nx) begin
                f_d.empty = 1'b0;
                f_d.irq   = 1'b0;
            end
        end
        if (clr) begin
            f_d.empty = 1'b1;
            f_d.fin   = 1'b1;
            f_d.irq   = irq_en;
            f_d.dma   = irq_en;
        end
        if (!irq_en) begin
            f_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{empty: 1'b1, fin: 1'b1, irq: 1'b0, dma: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign flag_empty = f_q.empty;
    assign flag_end   = f_q.fin;
    assign irq        = f_q.irq && irq_en;
    assign dma_req    = f_q.dma;

    assert_empty_at_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !above_nx) |=> f_q.empty);

    assert_end_only_when_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.fin) |-> zero_now);

    assert_dma_write_clears_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_dma && !clr) |=> !f_q.fin);

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.irq) |-> $past(irq_en));

endmodule

// File: rtl/tx_byte_queue.sv
module tx_byte_queue #(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int SW       = 2,
    parameter int THR_BASE = 8,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_from_dma,
    input  logic [DW-1:0] wr_data,
    input  logic          frame_tick,
    input  logic          tx_en,
    input  logic [SW-1:0] thr_sel,
    input  logic          fifo_clr,
    input  logic          irq_en,
    input  logic          sts_wr,
    input  logic          sts_end_val,
    input  logic          sts_empty_val,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    output logic [CW-1:0] level,
    output logic          flag_empty,
    output logic          flag_end,
    output logic          irq,
    output logic          dma_req
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic          push_ok, pop_ok, push_dma;
    logic [CW-1:0] level_nx;
    logic          above_now, above_nx, zero_now, zero_nx;

    assign push_ok  = wr_en && !fifo_clr && (level != FULL_LVL);
    assign pop_ok   = frame_tick && tx_en && !fifo_clr && (level != '0);
    assign push_dma = push_ok && wr_from_dma;

    txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fifo_clr),
        .push     (push_ok),
        .pop      (pop_ok),
        .din      (wr_data),
        .dout     (tx_data),
        .dout_vld (tx_valid),
        .level    (level),
        .level_nx (level_nx)
    );

    txq_limit #(.DEPTH(DEPTH), .SW(SW), .THR_BASE(THR_BASE)) u_limit (
        .sel       (thr_sel),
        .level_now (level),
        .level_nx  (level_nx),
        .above_now (above_now),
        .above_nx  (above_nx),
        .zero_now  (zero_now),
        .zero_nx   (zero_nx)
    );

    txq_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (fifo_clr),
        .pop           (pop_ok),
        .push_dma      (push_dma),
        .irq_en        (irq_en),
        .sts_wr        (sts_wr),
        .sts_end_val   (sts_end_val),
        .sts_empty_val (sts_empty_val),
        .above_now     (above_now),
        .above_nx      (above_nx),
        .zero_now      (zero_now),
        .zero_nx       (zero_nx),
        .flag_empty    (flag_empty),
        .flag_end      (flag_end),
        .irq           (irq),
        .dma_req       (dma_req)
    );

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && level == FULL_LVL && !pop_ok && !fifo_clr) |=> level == FULL_LVL);

    assert_send_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(frame_tick && tx_en));

    assert_cpu_write_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !wr_from_dma && !pop_ok && !sts_wr)
            |=> ($stable(flag_empty) && $stable(flag_end)));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (level == '0 && flag_empty && flag_end));

endmodule

// File: tb/tx_byte_queue_tb.sv
module tx_byte_queue_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_from_dma = 1'b0;
    logic [7:0] wr_data = '0;
    logic       frame_tick = 1'b0, tx_en = 1'b0;
    logic [1:0] thr_sel = '0;
    logic       fifo_clr = 1'b0, irq_en = 1'b0;
    logic       sts_wr = 1'b0, sts_end_val = 1'b1, sts_empty_val = 1'b1;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic [4:0] level;
    logic       flag_empty, flag_end, irq, dma_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tx_byte_queue u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_from_dma(wr_from_dma),
        .wr_data(wr_data), .frame_tick(frame_tick), .tx_en(tx_en),
        .thr_sel(thr_sel), .fifo_clr(fifo_clr), .irq_en(irq_en),
        .sts_wr(sts_wr), .sts_end_val(sts_end_val), .sts_empty_val(sts_empty_val),
        .tx_data(tx_data), .tx_valid(tx_valid), .level(level),
        .flag_empty(flag_empty), .flag_end(flag_end), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // state: level, empty, end, irq
    task automatic chk_st(input string tag, input int lv, input int e, input int f, input int i);
        chk({tag, " level"}, int'(level), lv);
        chk({tag, " flag_empty"}, int'(flag_empty), e);
        chk({tag, " flag_end"}, int'(flag_end), f);
        chk({tag, " irq"}, int'(irq), i);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 1'b0; frame_tick = 1'b0; fifo_clr = 1'b0;
        sts_wr = 1'b0; sts_end_val = 1'b1; sts_empty_val = 1'b1;
    endtask

    task automatic wr(input bit dma, input logic [7:0] b);
        wr_en = 1'b1; wr_from_dma = dma; wr_data = b;
        step();
    endtask

    task automatic tick();
        frame_tick = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk_st("R1 reset", 0, 1, 1, 0);
        chk("R1 reset dma_req", int'(dma_req), 0);
        chk("R1 reset tx_valid", int'(tx_valid), 0);
    endtask

    task automatic t_cpu_drain();
        irq_en = 1'b1; thr_sel = 2'd0;
        wr(1'b0, 8'hA1); wr(1'b0, 8'hA2); wr(1'b0, 8'hA3);
        chk_st("R7 cpu writes keep flags", 3, 1, 1, 0);
        tx_en = 1'b0; tick();
        chk("R2 no send without tx_en", int'(tx_valid), 0);
        chk("R2 level held without tx_en", int'(level), 3);
        tx_en = 1'b1; tick();
        chk("R2 valid on send", int'(tx_valid), 1);
        chk("R2 first byte", int'(tx_data), 'hA1);
        chk_st("R4 send under mark 8", 2, 1, 1, 1);
        chk("R4 dma pulse", int'(dma_req), 1);
        step();
        chk("R2 valid is one cycle", int'(tx_valid), 0);
        chk("R4 dma pulse one cycle", int'(dma_req), 0);
        tick(); chk("R2 second byte", int'(tx_data), 'hA2);
        tick(); chk("R2 third byte", int'(tx_data), 'hA3);
        chk_st("R5 end after drain", 0, 1, 1, 1);
    endtask

    task automatic t_dma_mark1();
        thr_sel = 2'd3;
        wr(1'b1, 8'h01);
        chk_st("R6 dma write at mark", 1, 1, 0, 1);
        wr(1'b1, 8'h02);
        chk_st("R6 dma write above mark", 2, 0, 0, 0);
        tick();
        chk_st("R4 sel3 reach mark 1", 1, 1, 0, 1);
        chk("R4 sel3 dma", int'(dma_req), 1);
        tick();
        chk_st("R5 sel3 drained", 0, 1, 1, 1);
    endtask

    task automatic t_mark2();
        thr_sel = 2'd2;
        for (int k = 0; k < 5; k++) wr(1'b1, 8'(8'h30 + k));
        chk_st("R6 five dma writes", 5, 0, 0, 0);
        tick(); chk("R4 sel2 level4 no dma", int'(dma_req), 0);
        chk("R4 sel2 level4 empty low", int'(flag_empty), 0);
        tick(); chk("R4 sel2 level3 no dma", int'(dma_req), 0);
        tick(); chk("R4 sel2 level2 dma", int'(dma_req), 1);
        chk_st("R4 sel2 at mark", 2, 1, 0, 1);
        tick(); tick();
        chk("R2 fifo order last", int'(tx_data), 'h34);
        chk_st("R5 sel2 drained", 0, 1, 1, 1);
        thr_sel = 2'd1;
        for (int k = 0; k < 5; k++) wr(1'b1, 8'h40);
        chk_st("R6 sel1 above mark 4", 5, 0, 0, 0);
        tick(); chk("R4 sel1 level4 dma", int'(dma_req), 1);
        for (int k = 0; k < 4; k++) tick();
        chk_st("R5 sel1 drained", 0, 1, 1, 1);
    endtask

    task automatic t_full();
        thr_sel = 2'd0;
        for (int k = 0; k < 17; k++) wr(1'b0, 8'(8'h10 + k));
        chk("R3 level capped", int'(level), 16);
        for (int k = 0; k < 16; k++) begin
            tick();
            chk("R3 drained byte order", int'(tx_data), 'h10 + k);
        end
        tick();
        chk("R3 dropped byte never sent", int'(tx_valid), 0);
        chk("R3 empty after drain", int'(level), 0);
    endtask

    task automatic t_status();
        thr_sel = 2'd0;
        sts_wr = 1'b1; sts_end_val = 1'b0; sts_empty_val = 1'b0; step();
        chk_st("R9 clears refused at level 0", 0, 1, 1, 1);
        for (int k = 0; k < 9; k++) wr(1'b0, 8'h55);
        chk_st("R7 cpu writes keep irq", 9, 1, 1, 1);
        sts_wr = 1'b1; sts_end_val = 1'b0; step();
        chk_st("R9 end cleared with data", 9, 1, 0, 1);
        sts_wr = 1'b1; sts_empty_val = 1'b0; step();
        chk_st("R9 empty cleared above mark", 9, 0, 0, 0);
        sts_wr = 1'b1; step();
        chk_st("R9 writing ones keeps flags", 9, 0, 0, 0);
    endtask

    task automatic t_clear();
        irq_en = 1'b0; fifo_clr = 1'b1; step();
        chk_st("R8 clear irq disabled", 0, 1, 1, 0);
        chk("R8 no dma when disabled", int'(dma_req), 0);
        wr(1'b0, 8'h66); wr(1'b0, 8'h67);
        irq_en = 1'b1; tx_en = 1'b1;
        fifo_clr = 1'b1; wr_en = 1'b1; wr_from_dma = 1'b0; frame_tick = 1'b1; step();
        chk_st("R8 clear wins over write and send", 0, 1, 1, 1);
        chk("R8 no send on clear", int'(tx_valid), 0);
        chk("R8 dma on clear", int'(dma_req), 1);
        step();
        chk("R8 dma one cycle", int'(dma_req), 0);
    endtask

    task automatic t_irq_en();
        irq_en = 1'b0; #1;
        chk("R10 irq drops at once", int'(irq), 0);
        step();
        irq_en = 1'b1; step();
        chk("R10 irq not restored", int'(irq), 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_cpu_drain();
        t_dma_mark1();
        t_mark2();
        t_full();
        t_status();
        t_clear();
        t_irq_en();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule